// File: doc/BRIEF.md
# Segment-Reversal XOR Switch-Control Generator

This block produces the switch settings for a rearrangeable binary permutation network with 2^n terminals. The network has 2n-1 stages of 2^(n-1) two-state switches. The block covers one family of permutations: reverse the lowest r address bits, then XOR the result with a constant k. With r = n the permutation is a full bit reversal. With r = 0 or r = 1 it is a plain XOR by k. The block never receives the permutation as a table. It starts from the two parameters and splits them down the recursive structure of the network, handling one tree depth per clock.

A run starts with a strobe that carries r in one-hot form and k in binary. On each of the next n cycles the block presents one stage pattern on its forward port: stages 1 to n, where stage n is the middle column. For every depth d below n, the pattern for the mirrored stage 2n-d is written into a hold bank at the same time. The datapath reads those patterns later, by stage number, when the vector reaches that stage. The run ends with a one-cycle done pulse, and a start strobe that arrives while a run is in progress is dropped.

Top module: `bxr_ctrl_gen`

## Requirements
- R1: After reset, busy, done and fwd_valid are 0, fwd_pat is all zero, and rd_pat reads zero for every rd_stage value.
- R2: When the block is idle, start is accepted at a clock edge E0 and busy is high after E0. Call E1 to En the n edges that follow E0. After edge Ed, fwd_valid is 1 and fwd_stage equals d.
- R3: done is high for exactly the cycle after En, together with stage n on the forward port. busy is low in that same cycle.
- R4: A start strobe that arrives while busy is high has no effect. The run in progress keeps its parameters and its timing, and no new run begins after it.
- R5: Parameter encoding: seg_u bit v is set exactly when r = v, for 0 ≤ r ≤ n. For a stage d < n, bit g of the forward pattern is bit (r-2d) of g when r ≥ 2d, and 0 otherwise.
- R6: Bit g of the pattern for stage 2n-1 is (bit r-2 of g) XOR k[r-1] XOR k[0] when r ≥ 2. When r ≤ 1, every bit of that pattern equals k[0].
- R7: Switch value 1 means crossed. At depth d, node c owns the 2^(n-d) switches that start at switch c·2^(n-d). In stage d, the node's local input 2i+b passes through switch i and enters child node 2c+(b XOR state) at local position i. At depth n, the single input b of node c leaves at b XOR (the state of stage-n switch c). In stage 2n-d, a path that comes back from child 2c+s at local position y passes through switch y and leaves the node at local position 2y+(s XOR state). Under these rules, all 2n-1 stage patterns together route every address x to rev_r(x) XOR k.
- R8: For n < rd_stage ≤ 2n-1, rd_pat returns the pattern stored for that stage by the most recent run, and it keeps that value after done. For any other rd_stage value, rd_pat is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe for a run |
| seg_u | input | N_LOG+1 | Reversal width r, one-hot |
| xor_k | input | N_LOG | XOR constant k |
| busy | output | 1 | A run is in progress |
| fwd_valid | output | 1 | The forward port holds a new stage pattern |
| fwd_stage | output | SW | Stage number of fwd_pat (1..n) |
| fwd_pat | output | 2^(N_LOG-1) | Switch settings for the first-half stage or the middle stage |
| done | output | 1 | One-cycle pulse when the last depth is produced |
| rd_stage | input | SW | Stage number to read from the hold bank |
| rd_pat | output | 2^(N_LOG-1) | Held pattern for rd_stage, or zero |

## Verification
The assertions assume that seg_u has exactly one bit set whenever a start is accepted. Under that assumption the reversal width stays a valid one-hot value through every depth of the run. The stimulus always builds seg_u as a single shifted bit, with r drawn from 0 to n. The bench also injects a start with different parameters in the middle of some runs. Those injected starts always land on an edge where the block is still busy, so they exercise R4 and never start a new run by accident.

// File: rtl/bxr_pkg.sv
package bxr_pkg;

   typedef enum logic {
      BXR_IDLE = 1'b0,
      BXR_RUN  = 1'b1
   } bxr_state_e;

   // width needed to number stages 1 .. 2n-1
   function automatic int stage_w(input int n);
      return $clog2(2 * n);
   endfunction

endpackage

// File: rtl/bxr_seq.sv
module bxr_seq #(
   parameter int N_LOG = 4,
   parameter int DW    = 3,
   parameter int GW    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [N_LOG:0]   seg_u,
   output logic             busy,
   output logic             accept,
   output logic             last,
   output logic [DW-1:0]    depth,
   output logic [N_LOG:0]   ru,
   output logic [GW-1:0]    half_sel,
   output logic             done
);
   import bxr_pkg::*;

   bxr_state_e     state_q;
   logic [DW-1:0]  depth_q;
   logic [N_LOG:0] ru_q;
   logic           done_q;
   logic           run;
   logic           rge2;

   assign run    = (state_q == BXR_RUN);
   assign accept = start && !run;
   assign last   = run && (depth_q == DW'(N_LOG));
   assign rge2   = |ru_q[N_LOG:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= BXR_IDLE;
         depth_q <= '0;
         ru_q    <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= last;
         if (accept) begin
            state_q <= BXR_RUN;
            depth_q <= DW'(1);
            ru_q    <= seg_u;
         end else if (run) begin
            if (last) begin
               state_q <= BXR_IDLE;
               depth_q <= '0;
            end else begin
               depth_q <= depth_q + DW'(1);
               // width shrinks by two per depth, floors at zero
               ru_q    <= rge2 ? (ru_q >> 2) : {{N_LOG{1'b0}}, 1'b1};
            end
         end
      end
   end

   // one-hot pick of the address bit that splits a node into its two sons
   always_comb begin
      for (int p = 0; p < GW; p++) begin
         half_sel[p] = run && (depth_q == DW'(N_LOG - 1 - p));
      end
   end

   assign busy  = run;
   assign depth = depth_q;
   assign ru    = ru_q;
   assign done  = done_q;

   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   assert_start_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && start && !last) |=> (run && depth_q == $past(depth_q) + DW'(1)));
   assert_seg_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> ($countones(seg_u) == 1));
   assert_width_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> ($countones(ru_q) == 1));

endmodule

// File: rtl/bxr_switch_cell.sv
module bxr_switch_cell #(
   parameter int N_LOG = 4,
   parameter int GW    = 3,
   parameter int G_IDX = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             advance,
   input  logic             last,
   input  logic [N_LOG-1:0] k_in,
   input  logic [N_LOG:0]   ru,
   input  logic [GW-1:0]    half_sel,
   output logic             fwd_b,
   output logic             back_b
);
   localparam logic [GW-1:0] GV = GW'(G_IDX);

   logic [N_LOG-1:0] kw;
   logic [N_LOG-1:0] inj;
   logic             rge2;
   logic             gsel;
   logic             krs;
   logic             side;

   assign rge2 = |ru[N_LOG:2];
   assign gsel = |(GV & ru[N_LOG:2]);   // bit r-2 of own switch index
   assign krs  = |(kw & ru[N_LOG:1]);   // k bit r-1 of owning node
   assign side = |(GV & half_sel);      // which son this switch falls into

   assign fwd_b  = last ? kw[0] : (rge2 & gsel);
   assign back_b = rge2 ? (gsel ^ krs ^ kw[0]) : kw[0];

   assign inj = side ? {1'b0, ru[N_LOG:2]} : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kw <= '0;
      end else if (load) begin
         kw <= k_in;
      end else if (advance && !last) begin
         kw <= (kw >> 1) ^ inj;
      end
   end

endmodule

// File: rtl/bxr_back_bank.sv
module bxr_back_bank #(
   parameter int N_LOG = 4,
   parameter int HALF  = 8,
   parameter int SW    = 3,
   parameter int DW    = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [DW-1:0]   wr_depth,
   input  logic [HALF-1:0] wr_pat,
   input  logic [SW-1:0]   rd_stage,
   output logic [HALF-1:0] rd_pat
);
   localparam int NE = N_LOG - 1;

   logic [HALF-1:0] bank_q [NE];

   for (genvar e = 1; e <= NE; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bank_q[e-1] <= '0;
         end else if (wr_en && (wr_depth == DW'(e))) begin
            bank_q[e-1] <= wr_pat;
         end
      end
   end

   always_comb begin
      rd_pat = '0;
      for (int e = 1; e <= NE; e++) begin
         if (rd_stage == SW'(2 * N_LOG - e)) rd_pat = bank_q[e-1];
      end
   end

endmodule

// File: rtl/bxr_ctrl_gen.sv
module bxr_ctrl_gen #(
   parameter int N_LOG = 4,
   localparam int HALF = 1 << (N_LOG - 1),
   localparam int GW   = N_LOG - 1,
   localparam int DW   = $clog2(N_LOG + 1),
   localparam int SW   = bxr_pkg::stage_w(N_LOG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [N_LOG:0]   seg_u,
   input  logic [N_LOG-1:0] xor_k,
   output logic             busy,
   output logic             fwd_valid,
   output logic [SW-1:0]    fwd_stage,
   output logic [HALF-1:0]  fwd_pat,
   output logic             done,
   input  logic [SW-1:0]    rd_stage,
   output logic [HALF-1:0]  rd_pat
);

   if (N_LOG < 2 || N_LOG > 12) begin : g_bad_n
      $error("bxr_ctrl_gen: N_LOG must lie in 2..12");
   end

   logic            accept;
   logic            last;
   logic [DW-1:0]   depth;
   logic [N_LOG:0]  ru;
   logic [GW-1:0]   half_sel;
   logic [HALF-1:0] fwd_vec;
   logic [HALF-1:0] back_vec;

   bxr_seq #(.N_LOG(N_LOG), .DW(DW), .GW(GW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .seg_u    (seg_u),
      .busy     (busy),
      .accept   (accept),
      .last     (last),
      .depth    (depth),
      .ru       (ru),
      .half_sel (half_sel),
      .done     (done)
   );

   for (genvar g = 0; g < HALF; g++) begin : g_sw
      bxr_switch_cell #(.N_LOG(N_LOG), .GW(GW), .G_IDX(g)) u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (accept),
         .advance  (busy),
         .last     (last),
         .k_in     (xor_k),
         .ru       (ru),
         .half_sel (half_sel),
         .fwd_b    (fwd_vec[g]),
         .back_b   (back_vec[g])
      );
   end

   bxr_back_bank #(.N_LOG(N_LOG), .HALF(HALF), .SW(SW), .DW(DW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (busy && !last),
      .wr_depth (depth),
      .wr_pat   (back_vec),
      .rd_stage (rd_stage),
      .rd_pat   (rd_pat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fwd_valid <= 1'b0;
         fwd_stage <= '0;
         fwd_pat   <= '0;
      end else begin
         fwd_valid <= busy;
         if (busy) begin
            fwd_stage <= SW'(depth);
            fwd_pat   <= fwd_vec;
         end
      end
   end

   assert_first_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> (fwd_valid && fwd_stage == SW'(1)));
   assert_stage_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid && busy) |=> (fwd_stage == $past(fwd_stage) + SW'(1)));
   assert_done_with_middle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (fwd_valid && fwd_stage == SW'(N_LOG)));

endmodule

// File: tb/bxr_ctrl_gen_tb.sv
module bxr_ctrl_gen_tb;
   localparam int N    = 4;
   localparam int HALF = 1 << (N - 1);
   localparam int SW   = $clog2(2 * N);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [N:0]      seg_u = '0;
   logic [N-1:0]    xor_k = '0;
   logic            busy, fwd_valid, done;
   logic [SW-1:0]   fwd_stage;
   logic [HALF-1:0] fwd_pat, rd_pat;
   logic [SW-1:0]   rd_stage = '0;

   always #2 clk = ~clk;

   bxr_ctrl_gen #(.N_LOG(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .seg_u(seg_u), .xor_k(xor_k),
      .busy(busy), .fwd_valid(fwd_valid), .fwd_stage(fwd_stage),
      .fwd_pat(fwd_pat), .done(done), .rd_stage(rd_stage), .rd_pat(rd_pat)
   );

   int  n_chk = 0;
   int  n_err = 0;
   bit  finished = 1'b0;
   logic [HALF-1:0] pat [1:2*N-1];

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int revr(input int x, input int r);
      int y = x;
      for (int b = 0; b < r; b++) y[b] = x[r-1-b];
      return y;
   endfunction

   // walk one address through the network under the R7 rules
   function automatic int route(input int x);
      int sv [N];
      int cv [N];
      int c = 0;
      int pos = x;
      int y;
      for (int d = 1; d < N; d++) begin
         int m = N - d + 1;
         int g = c * (1 << (m - 1)) + (pos >> 1);
         int s = (pos & 1) ^ int'(pat[d][g]);
         sv[d] = s;
         cv[d] = c;
         c = 2 * c + s;
         pos = pos >> 1;
      end
      y = pos ^ int'(pat[N][c]);
      for (int d = N - 1; d >= 1; d--) begin
         int m = N - d + 1;
         int g = cv[d] * (1 << (m - 1)) + y;
         y = 2 * y + (sv[d] ^ int'(pat[2*N-d][g]));
      end
      return y;
   endfunction

   task automatic run_case(input int r, input int k, input bit inject);
      logic [HALF-1:0] expv;
      @(negedge clk);
      start = 1'b1;
      seg_u = (N+1)'(1) << r;
      xor_k = N'(k);
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2 busy after start", busy, 1);
      for (int d = 1; d <= N; d++) begin
         if (inject && d == 1) begin
            start = 1'b1;
            seg_u = (N+1)'(1);
            xor_k = ~N'(k);
         end
         @(negedge clk);
         start = 1'b0;
         chk(fwd_valid == 1'b1, "R2 fwd_valid", fwd_valid, 1);
         chk(fwd_stage == SW'(d), "R2 fwd_stage", fwd_stage, d);
         chk(done == (d == N), "R3 done timing", done, (d == N));
         if (d == N) chk(busy == 1'b0, "R3 busy low at done", busy, 0);
         pat[d] = fwd_pat;
      end
      for (int st = N + 1; st <= 2 * N - 1; st++) begin
         rd_stage = SW'(st);
         #1;
         pat[st] = rd_pat;
      end
      // R5 forward patterns for stages below the middle
      for (int d = 1; d < N; d++) begin
         for (int g = 0; g < HALF; g++) expv[g] = (r >= 2 * d) ? g[r-2*d] : 1'b0;
         chk(pat[d] == expv, $sformatf("R5 stage %0d pattern r=%0d", d, r), pat[d], expv);
      end
      // R6 outermost back stage
      for (int g = 0; g < HALF; g++) begin
         if (r >= 2) expv[g] = g[r-2] ^ k[r-1] ^ k[0];
         else        expv[g] = k[0];
      end
      chk(pat[2*N-1] == expv, $sformatf("R6 last stage r=%0d k=%0d", r, k), pat[2*N-1], expv);
      // R7 routing of every address
      for (int x = 0; x < (1 << N); x++) begin
         int want = revr(x, r) ^ k;
         int got = route(x);
         chk(got == want, $sformatf("R7 route x=%0d r=%0d k=%0d", x, r, k), got, want);
      end
      // R4 / R3: nothing restarts, done has dropped
      @(negedge clk);
      chk(busy == 1'b0, "R4 no restart after run", busy, 0);
      chk(done == 1'b0, "R3 done one cycle", done, 0);
      // R8 hold and out-of-range reads
      rd_stage = SW'(2 * N - 1);
      #1;
      chk(rd_pat == pat[2*N-1], "R8 bank holds after done", rd_pat, pat[2*N-1]);
      rd_stage = SW'(N);
      #1;
      chk(rd_pat == '0, "R8 middle stage not in bank", rd_pat, 0);
      rd_stage = '0;
      #1;
      chk(rd_pat == '0, "R8 stage zero reads zero", rd_pat, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL R3 watchdog: run never completed actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd2741));
      repeat (3) @(negedge clk);
      // R1 reset state, checked while reset is asserted and after release
      chk(busy == 1'b0 && done == 1'b0 && fwd_valid == 1'b0, "R1 flags in reset",
          {busy, done, fwd_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(fwd_pat == '0, "R1 fwd_pat after reset", fwd_pat, 0);
      chk(busy == 1'b0, "R1 busy after reset", busy, 0);
      for (int st = 0; st < (1 << SW); st++) begin
         rd_stage = SW'(st);
         #1;
         chk(rd_pat == '0, $sformatf("R1 bank stage %0d", st), rd_pat, 0);
      end
      // directed corners
      run_case(N, 0, 1'b0);   // full reversal
      run_case(0, 5, 1'b0);   // pure XOR
      run_case(1, 15, 1'b1);  // width one equals pure XOR, with ignored start
      run_case(2, 9, 1'b0);
      run_case(3, 6, 1'b1);
      run_case(N, 15, 1'b1);
      // constrained random
      for (int i = 0; i < 24; i++) begin
         run_case(int'($urandom_range(0, N)), int'($urandom_range(0, (1 << N) - 1)),
                  bit'($urandom_range(0, 1)));
      end
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule